// File: doc/BRIEF.md
# Register-Pointer I2C Target

This block is the serial front end of a small byte-wide register bank. It answers on a two-wire serial bus at a 7-bit target address. Six upper address bits are fixed by a parameter. The lowest bit follows a strap input. Every access goes through one 8-bit pointer. After an addressed write, the first data byte loads the pointer. Each further byte, written or read, lands at the pointer, and the pointer then steps by one.

The pad logic supplies filtered SCL and SDA levels and one-cycle START and STOP pulses, all synchronous to the system clock. The block answers through an open-drain enable: a 1 on `sda_oe_o` pulls the line low. The register bank sees one address, which is the pointer. It returns the read data for that address together with two flags: whether the location exists and whether it may be written.

Locations that do not exist are refused with a NACK and read back as zero. The pointer still steps over them and wraps from FFh to 00h, so a burst can sweep the whole 8-bit space.

Top module: `i2c_regptr_slave`

## Requirements
- R1: During and right after reset, `sda_oe_o` is 0, `reg_addr_o` is 00h and `reg_wr_o` is 0.
- R2: The target answers only when the first byte after a START carries address {101011, `addr_sel_i`}, giving 56h or 57h. Bit 0 of that byte is the direction (0 write, 1 read). A matched address is ACKed in the ninth clock. A mismatch gets no ACK, and the block drives nothing until the next START.
- R3: In a write, the first data byte loads the pointer whatever its value. It is ACKed only when the bank reports the new location as valid.
- R4: A data byte is ACKed and stored only when the pointed location is both valid and writable. Storing means a one-cycle `reg_wr_o` pulse with `reg_addr_o` at the pointer and the byte on `reg_wdata_o`. Any other data byte is NACKed and not stored.
- R5: The pointer rises by one after every data byte, read or written, valid or not. It wraps from FFh to 00h.
- R6: Read bytes are sent MSB first, changing after SCL falling edges. A valid location returns `reg_rdata_i`; an invalid one returns 00h.
- R7: A read that follows a STOP, with no pointer byte in between, starts at the pointer value the previous transaction left.
- R8: A read burst continues while the master ACKs. After a master NACK, SDA stays released.
- R9: A repeated START in the middle of a byte discards that byte and restarts address reception.
- R10: A STOP returns the block to idle with SDA released and the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Filtered SCL level |
| sda_i | input | 1 | Filtered SDA level |
| start_i | input | 1 | One-cycle START or repeated START pulse |
| stop_i | input | 1 | One-cycle STOP pulse |
| addr_sel_i | input | 1 | Strap selecting the address LSB |
| reg_rdata_i | input | 8 | Read data of the pointed location |
| reg_valid_i | input | 1 | Pointed location exists |
| reg_writable_i | input | 1 | Pointed location accepts writes |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_addr_o | output | 8 | Register pointer |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |

## Verification
The bound checker watches the following on every cycle:
- A write strobe only ever meets a valid and writable location, and lasts one cycle.
- The pointer moves only by a load from a pointer byte or a step of exactly one.
- START and STOP put the controller into the right state with SDA released.
- Idle never drives the line.

Only the bench scenarios show the data-dependent behaviour: the ACK/NACK pattern of each byte, the MSB-first read values including zero for unmapped locations, the wrap across FFh, the pointer kept between transactions, the address strap, and the discard of a byte cut short by a repeated START.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_PTR   = 3'd2,
    ST_WDATA = 3'd3,
    ST_TX    = 3'd4
  } rp_state_t;
endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_i;
          sda_sh <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[STAGES-2:0], scl_i};
          sda_sh <= {sda_sh[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) scl_prev <= 1'b1;
    else     scl_prev <= scl_sh[STAGES-1];
  end

  assign sda_q    = sda_sh[STAGES-1];
  assign scl_rise = scl_sh[STAGES-1] & ~scl_prev;
  assign scl_fall = ~scl_sh[STAGES-1] & scl_prev;
endmodule

// File: rtl/i2c_rp_ptr.sv
module i2c_rp_ptr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] ptr_o
);
  always_ff @(posedge clk) begin
    if (rst)         ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + 1'b1;
  end
endmodule

// File: rtl/i2c_regptr_slave.sv
module i2c_regptr_slave
  import i2c_rp_pkg::*;
#(
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] SLV_HI      = 6'b101011
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          addr_sel_i,
  input  logic [DW-1:0] reg_rdata_i,
  input  logic          reg_valid_i,
  input  logic          reg_writable_i,
  output logic          sda_oe_o,
  output logic [DW-1:0] reg_addr_o,
  output logic          reg_wr_o,
  output logic [DW-1:0] reg_wdata_o
);
  localparam int            CW     = $clog2(DW + 2);
  localparam logic [CW-1:0] C_LAST = CW'(DW - 1);
  localparam logic [CW-1:0] C_FULL = CW'(DW);
  localparam logic [CW-1:0] C_ACK  = CW'(DW + 1);

  rp_state_t     st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg;
  logic          rw;
  logic          sda_q, scl_rise, scl_fall;
  logic          bus_evt, ptr_load, ptr_inc;
  logic [DW-1:0] tx_byte;

  i2c_rp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_q    (sda_q),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  always_comb begin
    bus_evt  = start_i | stop_i;
    tx_byte  = reg_valid_i ? reg_rdata_i : '0;
    ptr_load = !bus_evt && scl_rise && (st == ST_PTR) && (cnt == C_LAST);
    ptr_inc  = !bus_evt && scl_fall &&
               (((st == ST_TX) && (cnt == C_FULL)) ||
                ((st == ST_WDATA) && (cnt == C_ACK)));
  end

  i2c_rp_ptr #(.W(DW)) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (ptr_load),
    .load_val_i ({shreg[DW-2:0], sda_q}),
    .inc_i      (ptr_inc),
    .ptr_o      (reg_addr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      shreg       <= '0;
      rw          <= 1'b0;
      sda_oe_o    <= 1'b0;
      reg_wr_o    <= 1'b0;
      reg_wdata_o <= '0;
    end else begin
      reg_wr_o <= 1'b0;
      if (stop_i) begin
        st       <= ST_IDLE;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (cnt != C_ACK) cnt <= cnt + 1'b1;
          if (st == ST_TX) begin
            // ninth rise: master acknowledge bit
            if (cnt == C_FULL && sda_q) st <= ST_IDLE;
          end else if (cnt < C_FULL) begin
            shreg <= {shreg[DW-2:0], sda_q};
          end
        end else if (scl_fall) begin
          unique case (st)
            ST_ADDR: begin
              if (cnt == C_FULL) begin
                if (shreg[DW-1:1] == {SLV_HI, addr_sel_i}) begin
                  sda_oe_o <= 1'b1;
                  rw       <= shreg[0];
                end else begin
                  st <= ST_IDLE;
                end
              end else if (cnt == C_ACK) begin
                cnt <= '0;
                if (rw) begin
                  st       <= ST_TX;
                  shreg    <= tx_byte;
                  sda_oe_o <= ~tx_byte[DW-1];
                end else begin
                  st       <= ST_PTR;
                  sda_oe_o <= 1'b0;
                end
              end
            end
            ST_PTR: begin
              if (cnt == C_FULL) begin
                sda_oe_o <= reg_valid_i;
              end else if (cnt == C_ACK) begin
                sda_oe_o <= 1'b0;
                cnt      <= '0;
                st       <= ST_WDATA;
              end
            end
            ST_WDATA: begin
              if (cnt == C_FULL) begin
                if (reg_valid_i && reg_writable_i) begin
                  sda_oe_o    <= 1'b1;
                  reg_wr_o    <= 1'b1;
                  reg_wdata_o <= shreg;
                end
              end else if (cnt == C_ACK) begin
                sda_oe_o <= 1'b0;
                cnt      <= '0;
              end
            end
            ST_TX: begin
              if (cnt == C_FULL) begin
                sda_oe_o <= 1'b0;
              end else if (cnt == C_ACK) begin
                cnt      <= '0;
                shreg    <= tx_byte;
                sda_oe_o <= ~tx_byte[DW-1];
              end else if (cnt != '0) begin
                shreg    <= {shreg[DW-2:0], 1'b0};
                sda_oe_o <= ~shreg[DW-2];
              end
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_rp_checker.sv
module i2c_rp_checker
  import i2c_rp_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          stop_i,
  input logic          sda_oe_o,
  input logic          reg_wr_o,
  input logic          reg_valid_i,
  input logic          reg_writable_i,
  input logic [DW-1:0] reg_addr_o,
  input rp_state_t     st_q
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_wr_allowed_R4: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |-> (reg_valid_i && reg_writable_i));

  assert_wr_single_R4: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |=> !reg_wr_o);

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && reg_addr_o != $past(reg_addr_o) && $past(st_q) != ST_PTR)
      |-> ((reg_addr_o - $past(reg_addr_o)) == DW'(1)));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> !sda_oe_o);

  assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (start_i && !stop_i) |=> (st_q == ST_ADDR && !sda_oe_o));

  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (st_q == ST_IDLE && !sda_oe_o && $stable(reg_addr_o)));
endmodule

bind i2c_regptr_slave i2c_rp_checker #(.DW(DW)) u_rp_chk (
  .clk            (clk),
  .rst            (rst),
  .start_i        (start_i),
  .stop_i         (stop_i),
  .sda_oe_o       (sda_oe_o),
  .reg_wr_o       (reg_wr_o),
  .reg_valid_i    (reg_valid_i),
  .reg_writable_i (reg_writable_i),
  .reg_addr_o     (reg_addr_o),
  .st_q           (st)
);

// File: tb/i2c_regptr_slave_bench.sv
module i2c_regptr_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1, sda_m = 1'b1;
  logic       start_p = 1'b0, stop_p = 1'b0, addr_sel = 1'b0;
  logic       sda_oe, reg_wr, sda_line;
  logic [7:0] reg_addr, reg_wdata, rdata;
  logic       vflag, wflag;
  logic [7:0] regs [256];
  int         wr_count = 0;
  int         errors = 0, checks = 0;
  logic       ackv;
  logic [7:0] b;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign vflag    = (reg_addr <= 8'h07) || (reg_addr == 8'h0B);
  assign wflag    = vflag && (reg_addr >= 8'h02);
  assign rdata    = regs[reg_addr];

  i2c_regptr_slave u_i2c_regptr_slave (
    .clk (clk), .rst (rst), .scl_i (scl), .sda_i (sda_line),
    .start_i (start_p), .stop_i (stop_p), .addr_sel_i (addr_sel),
    .reg_rdata_i (rdata), .reg_valid_i (vflag), .reg_writable_i (wflag),
    .sda_oe_o (sda_oe), .reg_addr_o (reg_addr), .reg_wr_o (reg_wr),
    .reg_wdata_o (reg_wdata)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) regs[i] = 8'(i * 7 + 3);
    end else if (reg_wr) begin
      regs[reg_addr] = reg_wdata;
      wr_count = wr_count + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitc(H);
    scl = 1'b1;   waitc(H);
    sda_m = 1'b0; start_p = 1'b1; waitc(1); start_p = 1'b0;
    waitc(H); scl = 1'b0; waitc(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitc(H);
    scl = 1'b1;   waitc(H);
    sda_m = 1'b1; stop_p = 1'b1; waitc(1); stop_p = 1'b0;
    waitc(H);
  endtask

  task automatic bit_out(input logic v);
    sda_m = v; waitc(H);
    scl = 1'b1; waitc(H);
    scl = 1'b0;
  endtask

  task automatic bit_in(output logic v);
    sda_m = 1'b1; waitc(H);
    scl = 1'b1; waitc(H/2);
    v = sda_line; waitc(H/2);
    scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(last);
  endtask

  task automatic t_reset();
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 pointer", reg_addr, 8'h00);
    chk("R1 write strobe", reg_wr, 0);
  endtask

  task automatic t_wrong_addr();
    bus_start();
    send_byte(8'hAE, ackv); chk("R2 mismatch NACK", ackv, 0);
    send_byte(8'h02, ackv); chk("R2 silent after mismatch", ackv, 0);
    bus_stop();
    chk("R2 no write", wr_count, 0);
    chk("R2 pointer untouched", reg_addr, 8'h00);
  endtask

  task automatic t_page_write();
    bus_start();
    send_byte(8'hAC, ackv); chk("R2 match ACK", ackv, 1);
    send_byte(8'h02, ackv); chk("R3 valid pointer ACK", ackv, 1);
    send_byte(8'hAA, ackv); chk("R4 write 02 ACK", ackv, 1);
    send_byte(8'hBB, ackv); chk("R4 write 03 ACK", ackv, 1);
    send_byte(8'hCC, ackv); chk("R4 write 04 ACK", ackv, 1);
    bus_stop();
    chk("R4 three writes", wr_count, 3);
    chk("R5 R10 pointer after page", reg_addr, 8'h05);
  endtask

  task automatic t_bad_writes();
    bus_start();
    send_byte(8'hAC, ackv);
    send_byte(8'h08, ackv); chk("R3 invalid pointer NACK", ackv, 0);
    send_byte(8'h11, ackv); chk("R4 invalid 08 NACK", ackv, 0);
    send_byte(8'h12, ackv); chk("R4 invalid 09 NACK", ackv, 0);
    send_byte(8'h13, ackv); chk("R4 invalid 0A NACK", ackv, 0);
    send_byte(8'h02, ackv); chk("R5 stepped to 0B ACK", ackv, 1);
    bus_stop();
    chk("R4 one write stored", wr_count, 4);
    bus_start();
    send_byte(8'hAC, ackv);
    send_byte(8'h00, ackv); chk("R3 pointer 00 ACK", ackv, 1);
    send_byte(8'h77, ackv); chk("R4 read-only NACK", ackv, 0);
    bus_stop();
    chk("R4 read-only not stored", wr_count, 4);
    chk("R5 pointer after refused write", reg_addr, 8'h01);
  endtask

  task automatic t_read_ptr();
    bus_start();
    send_byte(8'hAC, ackv);
    send_byte(8'h02, ackv);
    bus_start();
    send_byte(8'hAD, ackv); chk("R9 R2 read address ACK", ackv, 1);
    recv_byte(1'b0, b); chk("R6 byte 02", b, 8'hAA);
    recv_byte(1'b0, b); chk("R6 R8 byte 03", b, 8'hBB);
    recv_byte(1'b0, b); chk("R6 R8 byte 04", b, 8'hCC);
    recv_byte(1'b1, b); chk("R6 byte 05", b, 8'h26);
    bit_in(ackv); chk("R8 released after NACK", ackv, 1);
    chk("R8 sda_oe low", sda_oe, 0);
    bus_stop();
    chk("R5 pointer after read", reg_addr, 8'h06);
  endtask

  task automatic t_current_read();
    bus_start();
    send_byte(8'hAD, ackv);
    recv_byte(1'b1, b); chk("R7 read from kept pointer", b, 8'h2D);
    bus_stop();
  endtask

  task automatic t_wrap();
    bus_start();
    send_byte(8'hAC, ackv);
    send_byte(8'hFE, ackv); chk("R3 pointer FE NACK", ackv, 0);
    bus_start();
    send_byte(8'hAD, ackv);
    recv_byte(1'b0, b); chk("R6 invalid FE reads zero", b, 8'h00);
    recv_byte(1'b0, b); chk("R6 invalid FF reads zero", b, 8'h00);
    recv_byte(1'b0, b); chk("R5 wrap to 00", b, 8'h03);
    recv_byte(1'b1, b); chk("R5 byte 01", b, 8'h0A);
    bus_stop();
    chk("R5 pointer after wrap", reg_addr, 8'h02);
  endtask

  task automatic t_addr_sel();
    addr_sel = 1'b1;
    bus_start();
    send_byte(8'hAD, ackv); chk("R2 56h refused when strap high", ackv, 0);
    bus_stop();
    bus_start();
    send_byte(8'hAF, ackv); chk("R2 57h ACK when strap high", ackv, 1);
    recv_byte(1'b1, b); chk("R2 read via 57h", b, 8'hAA);
    bus_stop();
    addr_sel = 1'b0;
  endtask

  task automatic t_abort();
    bus_start();
    send_byte(8'hAC, ackv);
    send_byte(8'h03, ackv);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_start();
    send_byte(8'hAD, ackv); chk("R9 address after abort ACK", ackv, 1);
    recv_byte(1'b1, b); chk("R9 partial byte discarded", b, 8'hBB);
    bus_stop();
    chk("R9 no write from partial byte", wr_count, 4);
  endtask

  initial begin
    waitc(4);
    t_reset();
    rst = 1'b0;
    waitc(2);
    t_reset();
    t_wrong_addr();
    t_page_write();
    t_bad_writes();
    t_read_ptr();
    t_current_read();
    t_wrap();
    t_addr_sel();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule